// File: doc/BRIEF.md
# 4x4 Lower-Triangular Matrix Inverter

This block inverts a 4x4 lower-triangular matrix held in signed fixed point. The caller places the ten entries on or below the diagonal on one wide input bus and raises a start pulse. The block latches them and splits the matrix into four 2x2 blocks. The upper-right block is zero, so it needs no work. Each diagonal block has a closed-form inverse built from its adjugate and its determinant. The lower-left block of the result is the negated product of the adjugate of the lower diagonal block, the off-diagonal input block and the adjugate of the upper diagonal block. That product is divided by the product of the two determinants.

All products pass one after another through a single signed multiplier, and every numerator is exact. The ten result entries then pass one after another through a single sequential divider. The divider rounds each quotient to nearest and clamps it to the output range. When the result is ready the block presents all ten entries at once with a one-cycle done pulse. A zero on the diagonal is caught at start, before any arithmetic runs. In that case the block raises a flag and produces no result.

Top module: `lt4_inverse`

## Requirements
- R1: While reset is high and in the first cycle after it, `inv_o` is all zero and `done_o` and `dz_o` are low.
- R2: Input and output entries are signed 16-bit values with 8 fraction bits (value = raw/256). Entry k sits at bits [16k+15:16k] in the order a11, a21, a22, a31, a32, a33, a41, a42, a43, a44, with k = 0 first. The output uses the same order for the inverse entries b11 to b44.
- R3: For a nonsingular input whose inverse lies in range, every output entry is within one LSB of the exact inverse entry scaled by 256.
- R4: Each diagonal output b_ii equals 65536/a_ii (raw values) rounded to nearest, so b_ii = 1/a_ii exactly rounded.
- R5: When both diagonal blocks are the identity, the lower-left output block (b31, b32, b41, b42) equals the negated input block (a31, a32, a41, a42) exactly.
- R6: An output entry whose exact value is above 32767 raw reads 32767 (0x7FFF). One below -32768 raw reads -32768 (0x8000).
- R7: A start with any diagonal entry (a11, a22, a33, a44) equal to zero sets `dz_o` and produces no `done_o` pulse. `inv_o` keeps its previous value. The next start with a nonzero diagonal clears `dz_o`.
- R8: A start pulse that arrives while a computation is in progress has no effect. The running computation finishes on its own inputs with a single done pulse.
- R9: `done_o` is high for exactly one cycle per result. `inv_o` changes only in the cycle in which `done_o` is high.
- R10: A quotient that falls exactly halfway between two output codes rounds away from zero. For example, -0.5 LSB reads -1 and +0.5 LSB reads +1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle pulse that latches `mat_i` and starts an inversion |
| mat_i | input | 160 | Ten packed input entries, Q8.8 |
| inv_o | output | 160 | Ten packed inverse entries, Q8.8, registered |
| done_o | output | 1 | One-cycle pulse when `inv_o` holds a new result |
| dz_o | output | 1 | Zero-diagonal flag from the most recent accepted start |

## Verification
A table of dense matrices with mixed signs, fractional entries and negative diagonals is compared against a floating-point forward-substitution inverse. The comparison allows one LSB, which separates a wrong partition term or a wrong scale from plain rounding. Pure diagonal and block-identity matrices isolate the determinant path and the lower-left sign and placement, and each gives one exact answer. Directed inputs probe the points where near misses show: a half-LSB tie on each sign, quotients that overflow in both directions, a zero on the diagonal after a valid result, and a restart issued in the middle of a computation.

// File: rtl/lt4_inv_pkg.sv
package lt4_inv_pkg;
  localparam int N_EL    = 10;  // stored entries of a 4x4 lower-triangular matrix
  localparam int N_MSTEP = 15;  // multiplier schedule length
  // packed positions of the diagonal entries
  localparam int IX_D1 = 0;
  localparam int IX_D2 = 2;
  localparam int IX_D3 = 5;
  localparam int IX_D4 = 9;

  typedef enum logic [1:0] {C_IDLE, C_MUL, C_DIV_GO, C_DIV_WAIT} ctl_st_t;
  typedef enum logic [1:0] {V_IDLE, V_RUN, V_FIN} div_st_t;
endpackage

// File: rtl/lt4_inv_mul.sv
// Shared signed multiplier, result kept modulo 2^OW (all stored products fit).
module lt4_inv_mul #(
  parameter int MW = 34,
  parameter int OW = 64
) (
  input  logic signed [MW-1:0] op_a,
  input  logic signed [MW-1:0] op_b,
  output logic signed [OW-1:0] prod
);
  assign prod = OW'(op_a) * OW'(op_b);
endmodule

// File: rtl/lt4_inv_div.sv
// Sequential restoring divider: q = round(num * 2^(2*FRAC) / den), clamped to DW bits.
// Requires 2*FRAC >= DW-1 so that |num| >= |den| always saturates.
module lt4_inv_div import lt4_inv_pkg::*; #(
  parameter int NW   = 50,
  parameter int DDW  = 64,
  parameter int DW   = 16,
  parameter int FRAC = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  go_i,
  input  logic signed [NW-1:0]  num_i,
  input  logic signed [DDW-1:0] den_i,
  output logic                  idle_o,
  output logic                  done_o,
  output logic signed [DW-1:0]  quo_o
);
  localparam int QB = 2*FRAC + 1;          // quotient bits incl. one rounding bit
  localparam int RW = DDW + 1;
  localparam int CW = $clog2(QB + 1);
  localparam logic [QB:0] NEG_LIM = (QB+1)'(1) << (DW-1);
  localparam logic [QB:0] POS_LIM = NEG_LIM - (QB+1)'(1);
  localparam logic signed [DW-1:0] QMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] QMIN = {1'b1, {(DW-1){1'b0}}};

  div_st_t          st;
  logic [RW-1:0]    rem, dv, rem_sh;
  logic [QB-1:0]    quo;
  logic [CW-1:0]    cnt;
  logic             neg, ovf;
  logic [NW-1:0]    num_mag;
  logic [DDW-1:0]   den_mag;
  logic [QB:0]      rnd;
  logic signed [DW-1:0] q_fin;

  always_comb begin
    num_mag = num_i[NW-1] ? -num_i : num_i;
    den_mag = den_i[DDW-1] ? -den_i : den_i;
    rem_sh  = rem << 1;
    rnd     = ({1'b0, quo} + (QB+1)'(1)) >> 1;
    if (ovf)      q_fin = neg ? QMIN : QMAX;
    else if (neg) q_fin = (rnd > NEG_LIM) ? QMIN : -rnd[DW-1:0];
    else          q_fin = (rnd > POS_LIM) ? QMAX : rnd[DW-1:0];
  end

  assign idle_o = (st == V_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= V_IDLE; done_o <= 1'b0; quo_o <= '0;
      rem <= '0; dv <= '0; quo <= '0; cnt <= '0; neg <= 1'b0; ovf <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        V_IDLE: if (go_i) begin
          rem <= RW'(num_mag);
          dv  <= RW'(den_mag);
          neg <= num_i[NW-1] ^ den_i[DDW-1];
          ovf <= (RW'(num_mag) >= RW'(den_mag));
          quo <= '0;
          cnt <= CW'(QB);
          st  <= V_RUN;
        end
        V_RUN: begin
          if (ovf) st <= V_FIN;
          else begin
            if (rem_sh >= dv) begin
              rem <= rem_sh - dv;
              quo <= {quo[QB-2:0], 1'b1};
            end else begin
              rem <= rem_sh;
              quo <= {quo[QB-2:0], 1'b0};
            end
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1)) st <= V_FIN;
          end
        end
        V_FIN: begin
          quo_o  <= q_fin;
          done_o <= 1'b1;
          st     <= V_IDLE;
        end
        default: st <= V_IDLE;
      endcase
    end
  end

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
    (st == V_RUN && !ovf) |-> (rem < dv)); // R3
  AST_NONZERO_DIVISOR: assert property (@(posedge clk) disable iff (rst)
    go_i |-> (den_i != '0)); // R7
endmodule

// File: rtl/lt4_inverse.sv
module lt4_inverse import lt4_inv_pkg::*; #(
  parameter int DW   = 16,
  parameter int FRAC = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [N_EL*DW-1:0]   mat_i,
  output logic [N_EL*DW-1:0]   inv_o,
  output logic                 done_o,
  output logic                 dz_o
);
  localparam int PW  = 2*DW;      // determinant / 2x2 product width
  localparam int RW  = 2*DW + 1;  // r terms
  localparam int HW  = 3*DW + 2;  // h terms
  localparam int DDW = 4*DW;      // product of determinants
  localparam int MW  = 2*DW + 2;  // multiplier operand width
  localparam int VW  = N_EL*DW;

  ctl_st_t st;
  logic [3:0] step, kx;
  logic [VW-1:0] a_q, res_q, res_nx;
  logic signed [DW-1:0]  e [N_EL];
  logic signed [PW-1:0]  p1, p2;
  logic signed [RW-1:0]  r11, r12, r21, r22;
  logic signed [HW-1:0]  h11, h12, h21, h22;
  logic signed [DDW-1:0] d12;
  logic signed [MW-1:0]  m_a, m_b;
  logic signed [DDW-1:0] m_p;
  logic signed [HW-1:0]  dv_num;
  logic signed [DDW-1:0] dv_den;
  logic dv_go, dv_idle, dv_done;
  logic signed [DW-1:0]  dv_q;
  logic diag_zero;

  for (genvar gi = 0; gi < N_EL; gi++) begin : g_el
    assign e[gi] = $signed(a_q[gi*DW +: DW]);
  end

  assign diag_zero = (mat_i[IX_D1*DW +: DW] == '0) || (mat_i[IX_D2*DW +: DW] == '0) ||
                     (mat_i[IX_D3*DW +: DW] == '0) || (mat_i[IX_D4*DW +: DW] == '0);

  // multiplier schedule: determinants, r = A21*adj(A11), h = adj(A22)*r, d1*d2
  always_comb begin
    m_a = '0; m_b = '0;
    case (step)
      4'd0:  begin m_a = MW'(e[0]); m_b = MW'(e[2]); end
      4'd1:  begin m_a = MW'(e[5]); m_b = MW'(e[9]); end
      4'd2:  begin m_a = MW'(e[3]); m_b = MW'(e[2]); end
      4'd3:  begin m_a = MW'(e[4]); m_b = MW'(e[1]); end
      4'd4:  begin m_a = MW'(e[4]); m_b = MW'(e[0]); end
      4'd5:  begin m_a = MW'(e[6]); m_b = MW'(e[2]); end
      4'd6:  begin m_a = MW'(e[7]); m_b = MW'(e[1]); end
      4'd7:  begin m_a = MW'(e[7]); m_b = MW'(e[0]); end
      4'd8:  begin m_a = MW'(e[9]); m_b = MW'(r11); end
      4'd9:  begin m_a = MW'(e[9]); m_b = MW'(r12); end
      4'd10: begin m_a = MW'(e[5]); m_b = MW'(r21); end
      4'd11: begin m_a = MW'(e[8]); m_b = MW'(r11); end
      4'd12: begin m_a = MW'(e[5]); m_b = MW'(r22); end
      4'd13: begin m_a = MW'(e[8]); m_b = MW'(r12); end
      4'd14: begin m_a = MW'(p1);   m_b = MW'(p2);  end
      default: ;
    endcase
  end

  lt4_inv_mul #(.MW(MW), .OW(DDW)) mul_i (.op_a(m_a), .op_b(m_b), .prod(m_p));

  // divider operands per output slot; every slot scales as N * 2^(2*FRAC) / D
  always_comb begin
    dv_num = '0; dv_den = '0;
    case (kx)
      4'd0: begin dv_num =  HW'(e[2]); dv_den = DDW'(p1); end
      4'd1: begin dv_num = -HW'(e[1]); dv_den = DDW'(p1); end
      4'd2: begin dv_num =  HW'(e[0]); dv_den = DDW'(p1); end
      4'd3: begin dv_num = -h11;       dv_den = d12;      end
      4'd4: begin dv_num = -h12;       dv_den = d12;      end
      4'd5: begin dv_num =  HW'(e[9]); dv_den = DDW'(p2); end
      4'd6: begin dv_num = -h21;       dv_den = d12;      end
      4'd7: begin dv_num = -h22;       dv_den = d12;      end
      4'd8: begin dv_num = -HW'(e[8]); dv_den = DDW'(p2); end
      4'd9: begin dv_num =  HW'(e[5]); dv_den = DDW'(p2); end
      default: ;
    endcase
    res_nx = res_q;
    res_nx[kx*DW +: DW] = dv_q;
  end

  assign dv_go = (st == C_DIV_GO);

  lt4_inv_div #(.NW(HW), .DDW(DDW), .DW(DW), .FRAC(FRAC)) div_i (
    .clk(clk), .rst(rst), .go_i(dv_go), .num_i(dv_num), .den_i(dv_den),
    .idle_o(dv_idle), .done_o(dv_done), .quo_o(dv_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= C_IDLE; step <= '0; kx <= '0;
      a_q <= '0; res_q <= '0; inv_o <= '0; done_o <= 1'b0; dz_o <= 1'b0;
      p1 <= '0; p2 <= '0; r11 <= '0; r12 <= '0; r21 <= '0; r22 <= '0;
      h11 <= '0; h12 <= '0; h21 <= '0; h22 <= '0; d12 <= '0;
    end else begin
      done_o <= 1'b0;
      case (st)
        C_IDLE: if (start_i) begin
          a_q <= mat_i;
          if (diag_zero) dz_o <= 1'b1;
          else begin
            dz_o <= 1'b0; step <= '0; st <= C_MUL;
          end
        end
        C_MUL: begin
          case (step)
            4'd0:  p1  <= m_p[PW-1:0];
            4'd1:  p2  <= m_p[PW-1:0];
            4'd2:  r11 <= m_p[RW-1:0];
            4'd3:  r11 <= r11 - m_p[RW-1:0];
            4'd4:  r12 <= m_p[RW-1:0];
            4'd5:  r21 <= m_p[RW-1:0];
            4'd6:  r21 <= r21 - m_p[RW-1:0];
            4'd7:  r22 <= m_p[RW-1:0];
            4'd8:  h11 <= m_p[HW-1:0];
            4'd9:  h12 <= m_p[HW-1:0];
            4'd10: h21 <= m_p[HW-1:0];
            4'd11: h21 <= h21 - m_p[HW-1:0];
            4'd12: h22 <= m_p[HW-1:0];
            4'd13: h22 <= h22 - m_p[HW-1:0];
            4'd14: d12 <= m_p;
            default: ;
          endcase
          if (step == 4'(N_MSTEP-1)) begin
            st <= C_DIV_GO; kx <= '0;
          end else step <= step + 4'd1;
        end
        C_DIV_GO: st <= C_DIV_WAIT;
        C_DIV_WAIT: if (dv_done) begin
          res_q <= res_nx;
          if (kx == 4'(N_EL-1)) begin
            inv_o <= res_nx; done_o <= 1'b1; st <= C_IDLE;
          end else begin
            kx <= kx + 4'd1; st <= C_DIV_GO;
          end
        end
        default: st <= C_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(inv_o)); // R9
  AST_DZ_BLOCKS_DONE: assert property (@(posedge clk) disable iff (rst)
    dz_o |-> !done_o); // R7
  AST_DIV_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    dv_go |-> dv_idle); // R8
endmodule

// File: tb/lt4_inverse_tb_top.sv
module lt4_inverse_tb_top;
  localparam int DW = 16;
  localparam int NE = 10;
  localparam int VW = NE*DW;
  localparam int NV = 6;
  // a11, a21, a22, a31, a32, a33, a41, a42, a43, a44 (raw Q8.8)
  localparam int TBL [NV][NE] = '{
    '{256, 0, 256, 0, 0, 256, 0, 0, 0, 256},
    '{512, 0, 1024, 0, 0, 128, 0, 0, 0, 2048},
    '{512, 256, 768, -128, 384, 1024, 64, -256, 512, 640},
    '{-512, 128, 640, 256, -256, -768, 384, 128, -64, 1280},
    '{96, -32, 160, 48, 64, 200, -80, 100, 30, 300},
    '{2560, -1280, -3840, 640, 1920, 5120, -640, 1280, -2560, -7680}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [VW-1:0] mat = '0;
  logic [VW-1:0] inv;
  logic done, dz;
  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  lt4_inverse #(.DW(DW), .FRAC(8)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .mat_i(mat),
    .inv_o(inv), .done_o(done), .dz_o(dz));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int el(input logic [VW-1:0] v, input int i);
    logic signed [DW-1:0] x;
    x = v[i*DW +: DW];
    return int'(x);
  endfunction

  function automatic int ref_el(input logic [VW-1:0] m, input int idx);
    real l [4][4];
    real b [4][4];
    real s, raw;
    int r = 0;
    int c = 0;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        l[i][j] = 0.0; b[i][j] = 0.0;
      end
    for (int i = 0; i < 4; i++)
      for (int j = 0; j <= i; j++) begin
        l[i][j] = $itor(el(m, i*(i+1)/2 + j)) / 256.0;
        if (i*(i+1)/2 + j == idx) begin r = i; c = j; end
      end
    for (int j = 0; j < 4; j++) begin
      b[j][j] = 1.0 / l[j][j];
      for (int i = j + 1; i < 4; i++) begin
        s = 0.0;
        for (int k = j; k < i; k++) s = s + l[i][k] * b[k][j];
        b[i][j] = -s / l[i][i];
      end
    end
    raw = b[r][c] * 256.0;
    if (raw > 32767.0) return 32767;
    if (raw < -32768.0) return -32768;
    return (raw >= 0.0) ? $rtoi(raw + 0.5) : -$rtoi(-raw + 0.5);
  endfunction

  function automatic int diag_exp(input int a);
    int q2, mag, v;
    q2 = 131072 / ((a < 0) ? -a : a);
    mag = (q2 + 1) / 2;
    v = (a < 0) ? -mag : mag;
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return v;
  endfunction

  function automatic logic [VW-1:0] pack10(input int v0, input int v1, input int v2,
      input int v3, input int v4, input int v5, input int v6, input int v7,
      input int v8, input int v9);
    logic [VW-1:0] m;
    m = {16'(v9), 16'(v8), 16'(v7), 16'(v6), 16'(v5), 16'(v4), 16'(v3), 16'(v2), 16'(v1), 16'(v0)};
    return m;
  endfunction

  task automatic run_mat(input logic [VW-1:0] m, output logic [VW-1:0] res, output bit got);
    @(negedge clk); mat = m; start = 1'b1;
    @(negedge clk); start = 1'b0;
    got = 1'b0;
    res = '0;
    for (int c = 0; c < 2000; c++) begin
      if (done) begin got = 1'b1; break; end
      @(negedge clk);
    end
    if (got) begin
      res = inv;
      @(negedge clk);
      check(done == 1'b0, "R9 done lasts one cycle", int'(done), 0);
      check(inv == res, "R9 output held after done", el(inv, 0), el(res, 0));
    end else check(1'b0, "R3 result never arrived", 0, 1);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] m, res, prev;
    bit got, saw;
    repeat (3) @(negedge clk);
    check(inv == '0, "R1 output zero in reset", el(inv, 0), 0);
    check(done == 1'b0, "R1 done low in reset", int'(done), 0);
    check(dz == 1'b0, "R1 flag low in reset", int'(dz), 0);
    rst = 1'b0;
    @(negedge clk);
    check(inv == '0 && !done && !dz, "R1 idle after reset", el(inv, 0), 0);

    // table walk: R3 against reference, R4 exact diagonal
    for (int i = 0; i < NV; i++) begin
      m = '0;
      for (int j = 0; j < NE; j++) m[j*DW +: DW] = 16'(TBL[i][j]);
      run_mat(m, res, got);
      for (int j = 0; j < NE; j++) begin
        int a, x, d;
        a = el(res, j); x = ref_el(m, j); d = a - x;
        if (d < 0) d = -d;
        check(d <= 1, "R3 entry within one LSB", a, x);
      end
      check(el(res, 0) == diag_exp(TBL[i][0]), "R4 b11", el(res, 0), diag_exp(TBL[i][0]));
      check(el(res, 2) == diag_exp(TBL[i][2]), "R4 b22", el(res, 2), diag_exp(TBL[i][2]));
      check(el(res, 5) == diag_exp(TBL[i][5]), "R4 b33", el(res, 5), diag_exp(TBL[i][5]));
      check(el(res, 9) == diag_exp(TBL[i][9]), "R4 b44", el(res, 9), diag_exp(TBL[i][9]));
    end

    // R5 / R2: identity diagonal blocks, lower-left block negated in place
    run_mat(pack10(256, 0, 256, 384, -512, 256, 64, 768, 0, 256), res, got);
    check(el(res, 3) == -384, "R5 R2 b31", el(res, 3), -384);
    check(el(res, 4) == 512,  "R5 R2 b32", el(res, 4), 512);
    check(el(res, 6) == -64,  "R5 R2 b41", el(res, 6), -64);
    check(el(res, 7) == -768, "R5 R2 b42", el(res, 7), -768);
    check(el(res, 1) == 0 && el(res, 8) == 0, "R2 diagonal-block off entries", el(res, 1), 0);

    // R6: saturation both ways
    run_mat(pack10(1, 0, 256, 0, 0, -1, 0, 0, 0, 256), res, got);
    check(el(res, 0) == 32767,  "R6 positive clamp", el(res, 0), 32767);
    check(el(res, 5) == -32768, "R6 negative clamp", el(res, 5), -32768);
    check(el(res, 2) == 256 && el(res, 9) == 256, "R6 neighbours unaffected", el(res, 2), 256);

    // R10: half-LSB ties
    run_mat(pack10(512, 2, 512, 0, 0, 512, 0, 0, -2, 512), res, got);
    check(el(res, 1) == -1, "R10 negative tie", el(res, 1), -1);
    check(el(res, 8) == 1,  "R10 positive tie", el(res, 8), 1);
    check(el(res, 0) == 128, "R10 b11", el(res, 0), 128);

    // R7: zero diagonal after a valid result
    run_mat(pack10(256, 0, 256, 0, 0, 256, 0, 0, 0, 256), prev, got);
    @(negedge clk); mat = pack10(256, 0, 0, 0, 0, 256, 0, 0, 0, 256); start = 1'b1;
    @(negedge clk); start = 1'b0;
    saw = 1'b0;
    for (int c = 0; c < 400; c++) begin
      if (done) saw = 1'b1;
      @(negedge clk);
    end
    check(!saw, "R7 no done on zero diagonal", int'(saw), 0);
    check(dz == 1'b1, "R7 flag set", int'(dz), 1);
    check(inv == prev, "R7 output unchanged", el(inv, 0), el(prev, 0));
    run_mat(pack10(512, 0, 1024, 0, 0, 128, 0, 0, 0, 2048), res, got);
    check(dz == 1'b0, "R7 flag cleared by valid start", int'(dz), 0);
    check(el(res, 9) == 32, "R7 valid run after flag", el(res, 9), 32);

    // R8: restart during computation ignored
    m = '0;
    for (int j = 0; j < NE; j++) m[j*DW +: DW] = 16'(TBL[2][j]);
    @(negedge clk); mat = m; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    mat = pack10(256, 0, 256, 0, 0, 256, 0, 0, 0, 256); start = 1'b1;
    @(negedge clk); start = 1'b0;
    got = 1'b0;
    for (int c = 0; c < 2000; c++) begin
      if (done) begin got = 1'b1; break; end
      @(negedge clk);
    end
    res = inv;
    check(got, "R8 first computation completes", int'(got), 1);
    for (int j = 0; j < NE; j++) begin
      int a, x, d;
      a = el(res, j); x = ref_el(m, j); d = a - x;
      if (d < 0) d = -d;
      check(d <= 1, "R8 result from first inputs", a, x);
    end
    saw = 1'b0;
    @(negedge clk);
    for (int c = 0; c < 400; c++) begin
      if (done) saw = 1'b1;
      @(negedge clk);
    end
    check(!saw, "R8 no second done", int'(saw), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule